// File: doc/BRIEF.md
# Dual-Port Semaphore Token Bank

This block holds eight binary tokens that two agents, one on a left port and one on a right port, use to claim shared resources by software convention. The tokens live in an address space of their own. An agent claims a token by writing a zero into it. It then reads the token back to learn whether the claim succeeded, and it gives the token up by writing a one. Each token keeps one request flag per side. A request from the side that does not hold the token waits in its flag, and the token passes to that side as soon as the holder releases it.

Each port has a select strobe, a write strobe, an output enable, an address bus and 16-bit write and read data buses. Only the lowest three address bits choose the token, and only bit 0 of the write data carries meaning. A read presents the reading side's own view of the token, either 0 for "held by me" or 1 for "not held by me", replicated across the whole read bus. The value is captured when the read access opens and is held until the access closes. A polling agent must therefore drop select or output enable between two polls.

The interface has no data stream, so it uses no valid/ready handshake. All strobes are plain levels sampled on each rising clock edge. The block never applies back-pressure: every access is accepted in the cycle it is presented, and a write stays in force for every cycle its strobes are held.

Top module: `sema_bank`

## Requirements
- R1: After reset, all sixteen request flags are released and every token is free. A read of any token from either side returns 16'hFFFF.
- R2: The token index is address bits [2:0]. Address bits above bit 2 have no effect on which token is read or written.
- R3: A write (select=1, write=1 at a rising edge) loads write-data bit 0 into that side's request flag for the indexed token. Writing 0 to a free token gives it to the writer from the next cycle: the writer's view becomes 0 and the other side's view stays 1.
- R4: While one side holds a token, a 0 written by the other side is kept as a pending request, and neither side's view changes. A 0 written by the holder leaves the views unchanged as well.
- R5: When the holder writes 1, the token passes in the same edge to the other side if that side has a pending 0, so the views swap. Otherwise both views become 1 (free).
- R6: A read returns the side's view on all 16 data bits (16'h0000 or 16'hFFFF). Write-data bits [15:1] have no effect on the token.
- R7: A read access (select=1, write=0, output enable=1) captures the view at the first rising edge of the access. The read bus shows the captured value from that edge on and keeps it unchanged while the access stays open, even if the view changes. With no open read access, the read bus is 16'h0000.
- R8: If both sides write 0 to a free token at the same edge, the left side gets the token, and the right side's 0 stays pending.
- R9: An access to one token leaves all other tokens unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left token-space select |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left output enable for reads |
| l_addr | input | ADDR_W (13) | Left address; bits [2:0] pick the token |
| l_wdata | input | DATA_W (16) | Left write data; bit 0 used |
| l_rdata | output | DATA_W (16) | Left read data |
| r_sel | input | 1 | Right token-space select |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe | input | 1 | Right output enable for reads |
| r_addr | input | ADDR_W (13) | Right address; bits [2:0] pick the token |
| r_wdata | input | DATA_W (16) | Right write data; bit 0 used |
| r_rdata | output | DATA_W (16) | Right read data |

## Verification
The ownership properties assume that a side's write strobe is a clean level per cycle and that a side never reads and writes in the same cycle. The stimulus guarantees this by raising select together with either the write strobe or the output enable, never both. The freeze property assumes that a read access is closed by dropping a strobe. The stimulus therefore always brings select or output enable low for at least one cycle between two reads that must see fresh values. Same-edge requests are driven deliberately on a free token to exercise the fixed left priority. All other writes from the two sides are spaced in separate cycles, so every expected view follows from a single step of the handover rules.

// File: rtl/sema_pkg.sv
package sema_pkg;

  typedef enum logic [1:0] {
    TOK_FREE  = 2'd0,
    TOK_LEFT  = 2'd1,
    TOK_RIGHT = 2'd2
  } tok_state_e;

  // Next holder from the current holder and the active-low request flags
  // as they stand after this edge's writes.
  function automatic tok_state_e tok_next(input tok_state_e cur,
                                          input logic req_l_n,
                                          input logic req_r_n);
    tok_state_e nxt;
    case (cur)
      TOK_LEFT:  nxt = !req_l_n ? TOK_LEFT  : (!req_r_n ? TOK_RIGHT : TOK_FREE);
      TOK_RIGHT: nxt = !req_r_n ? TOK_RIGHT : (!req_l_n ? TOK_LEFT  : TOK_FREE);
      default:   nxt = !req_l_n ? TOK_LEFT  : (!req_r_n ? TOK_RIGHT : TOK_FREE);
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/sema_write_dec.sv
module sema_write_dec #(
  parameter int NUM_TOK = 8,
  parameter int IDX_W   = $clog2(NUM_TOK)
) (
  input  logic               sel,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_TOK-1:0] wen
);
  for (genvar i = 0; i < NUM_TOK; i++) begin : g_dec
    assign wen[i] = sel && we && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/sema_token.sv
module sema_token
  import sema_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_l,
  input  logic d_l,
  input  logic wr_r,
  input  logic d_r,
  output logic view_l,
  output logic view_r
);
  logic       req_l_q, req_r_q;
  logic       req_l_nx, req_r_nx;
  tok_state_e own_q;

  assign req_l_nx = wr_l ? d_l : req_l_q;
  assign req_r_nx = wr_r ? d_r : req_r_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_l_q <= 1'b1;
      req_r_q <= 1'b1;
      own_q   <= TOK_FREE;
    end else begin
      req_l_q <= req_l_nx;
      req_r_q <= req_r_nx;
      own_q   <= tok_next(own_q, req_l_nx, req_r_nx);
    end
  end

  assign view_l = (own_q != TOK_LEFT);
  assign view_r = (own_q != TOK_RIGHT);

  // R3 R8
  grant_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == TOK_FREE && wr_l && !d_l) |=> (!view_l && view_r));

  // R4
  hold_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == TOK_LEFT && !(wr_l && d_l)) |=> (!view_l && view_r));

  // R5
  pass_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == TOK_LEFT && wr_l && d_l && !wr_r && !req_r_q) |=> (view_l && !view_r));

  // R5
  free_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == TOK_RIGHT && wr_r && d_r && !wr_l && req_l_q) |=> (view_l && view_r));
endmodule

// File: rtl/sema_read_port.sv
module sema_read_port #(
  parameter int NUM_TOK = 8,
  parameter int IDX_W   = $clog2(NUM_TOK),
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               we,
  input  logic               oe,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_TOK-1:0] views,
  output logic [DATA_W-1:0]  rdata
);
  logic act, act_q, hold_q;

  assign act = sel && !we && oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      act_q <= act;
      if (act && !act_q) hold_q <= views[idx];
    end
  end

  assign rdata = act_q ? {DATA_W{hold_q}} : '0;

  // R7
  read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && act) |=> $stable(rdata));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act) |=> (rdata == '0));
endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int NUM_TOK = 8,
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = $clog2(NUM_TOK);

  logic [IDX_W-1:0]   l_idx, r_idx;
  logic [NUM_TOK-1:0] l_wen, r_wen, view_l, view_r;

  // R2: only the low index bits reach the token logic
  assign l_idx = l_addr[IDX_W-1:0];
  assign r_idx = r_addr[IDX_W-1:0];

  sema_write_dec #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_dec_l (
    .sel(l_sel), .we(l_we), .idx(l_idx), .wen(l_wen));
  sema_write_dec #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W)) u_dec_r (
    .sel(r_sel), .we(r_we), .idx(r_idx), .wen(r_wen));

  for (genvar i = 0; i < NUM_TOK; i++) begin : g_tok
    sema_token u_tok (
      .clk(clk), .rst_n(rst_n),
      .wr_l(l_wen[i]), .d_l(l_wdata[0]),
      .wr_r(r_wen[i]), .d_r(r_wdata[0]),
      .view_l(view_l[i]), .view_r(view_r[i]));
  end

  sema_read_port #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .sel(l_sel), .we(l_we), .oe(l_oe),
    .idx(l_idx), .views(view_l), .rdata(l_rdata));
  sema_read_port #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .sel(r_sel), .we(r_we), .oe(r_oe),
    .idx(r_idx), .views(view_r), .rdata(r_rdata));

  // R9: a write touches at most one token per side
  one_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(l_wen) && $onehot0(r_wen));
endmodule

// File: tb/sema_bank_bench.sv
module sema_bank_bench;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 16;
  localparam logic [15:0] ONES = 16'hFFFF;
  localparam logic [15:0] ZERO = 16'h0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_we = 0, l_oe = 0, r_sel = 0, r_we = 0, r_oe = 0;
  logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
  logic [DATA_W-1:0] l_wdata = '0, r_wdata = '0;
  logic [DATA_W-1:0] l_rdata, r_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          side;
    logic [15:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  sema_bank u_sema_bank (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata));

  // monitor: compares queued expectations after each rising edge
  initial forever begin
    @(posedge clk);
    #2;
    while (sb.size() > 0) begin
      exp_t it;
      logic [15:0] got;
      it = sb.pop_front();
      got = (it.side == 0) ? l_rdata : r_rdata;
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s side=%0d got=%h exp=%h", it.tag, it.side, got, it.exp);
      end
    end
  end

  function automatic logic [ADDR_W-1:0] mk_addr(input int idx, input int hi);
    return ADDR_W'(hi * 8 + (idx % 8));
  endfunction

  task automatic push(input int side, input logic [15:0] e, input string tag);
    exp_t it;
    it.side = side; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drive(input int side, input logic s, input logic w, input logic o,
                       input logic [ADDR_W-1:0] a, input logic [15:0] d);
    if (side == 0) begin
      l_sel = s; l_we = w; l_oe = o; l_addr = a; l_wdata = d;
    end else begin
      r_sel = s; r_we = w; r_oe = o; r_addr = a; r_wdata = d;
    end
  endtask

  task automatic do_wr(input int side, input int idx, input logic [15:0] d, input int hi);
    @(negedge clk);
    drive(side, 1, 1, 0, mk_addr(idx, hi), d);
    @(negedge clk);
    drive(side, 0, 0, 0, '0, '0);
  endtask

  task automatic do_rd(input int side, input int idx, input logic [15:0] e,
                       input int hi, input string tag);
    @(negedge clk);
    drive(side, 1, 0, 1, mk_addr(idx, hi), '0);
    push(side, e, tag);
    @(negedge clk);
    drive(side, 0, 0, 0, '0, '0);
  endtask

  task automatic views(input int idx, input logic vl, input logic vr, input int hi,
                       input string tag);
    do_rd(0, idx, {16{vl}}, hi, tag);
    do_rd(1, idx, {16{vr}}, hi + 3, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, and idle bus reads zero (R7)
    @(negedge clk);
    push(0, ZERO, "R7 idle");
    push(1, ZERO, "R7 idle");
    for (int t = 0; t < 8; t++) views(t, 1, 1, t, "R1 reset free");

    // R3 R4 R5 R6 R2: handover sequence on every token, high address bits varied
    for (int t = 0; t < 8; t++) begin
      do_wr(0, t, 16'hFFFE, t + 1);            // request, upper bits set (R6)
      views(t, 0, 1, 2 * t, "R3 left takes");
      do_rd(0, (t + 1) % 8, ONES, 5, "R9 neighbour untouched");
      do_wr(1, t, 16'h0000, 7);
      views(t, 0, 1, t + 4, "R4 right pends");
      do_wr(0, t, 16'h0001, 0);
      views(t, 1, 0, 9, "R5 handover to right");
      do_wr(0, t, 16'h0000, 2);
      views(t, 1, 0, 1, "R4 left pends");
      do_wr(1, t, 16'h8001, 3);
      views(t, 0, 1, 6, "R5 handover to left");
      do_wr(0, t, 16'h0001, 12);
      views(t, 1, 1, 11, "R5 release frees");
      do_wr(1, t, 16'h0000, 0);
      views(t, 1, 0, 20, "R3 right takes free");
      do_wr(1, t, 16'hFFFF, 0);
      views(t, 1, 1, 21, "R5 right release frees");
    end

    // R8: simultaneous requests on a free token
    @(negedge clk);
    drive(0, 1, 1, 0, mk_addr(5, 2), 16'h0000);
    drive(1, 1, 1, 0, mk_addr(5, 9), 16'h0000);
    @(negedge clk);
    drive(0, 0, 0, 0, '0, '0);
    drive(1, 0, 0, 0, '0, '0);
    views(5, 0, 1, 0, "R8 left wins tie");
    do_wr(0, 5, 16'h0001, 0);
    views(5, 1, 0, 0, "R8 right request kept");
    do_wr(1, 5, 16'h0001, 0);
    views(5, 1, 1, 0, "R8 cleanup free");

    // R7: frozen read while the view changes underneath
    do_wr(0, 2, 16'h0000, 0);
    do_wr(1, 2, 16'h0000, 0);
    @(negedge clk);
    drive(1, 1, 0, 1, mk_addr(2, 4), '0);
    push(1, ONES, "R7 capture pending view");
    @(negedge clk);
    drive(0, 1, 1, 0, mk_addr(2, 0), 16'h0001);   // left releases, right now holds
    push(1, ONES, "R7 frozen during handover");
    @(negedge clk);
    drive(0, 0, 0, 0, '0, '0);
    push(1, ONES, "R7 still frozen");
    @(negedge clk);
    r_oe = 1'b0;
    push(1, ZERO, "R7 closed access");
    @(negedge clk);
    r_oe = 1'b1;
    push(1, ZERO, "R7 fresh view after toggle");
    @(negedge clk);
    drive(1, 0, 0, 0, '0, '0);
    do_wr(1, 2, 16'h0001, 0);
    views(2, 1, 1, 0, "R9 final free");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule